// File: doc/BRIEF.md
# Shift-and-Add Montgomery Modular Multiplier (q = 3329)

This block multiplies two 12-bit residues modulo the prime 3329 without a hard multiplier. Four 6×6 AND-array multipliers build the 24-bit integer product. A Montgomery reduction with R = 2^16 then scales it by R^-1 and brings it into [0, 3329). The reduction uses only shifts, additions, subtractions and one two's-complement negation, because 3329 = 2^12 − 2^9 − 2^8 + 1 has only a few nonzero terms.

In a transform pipeline, one operand is a data coefficient. The other is a twiddle factor that was stored already multiplied by 2^16 mod 3329. The extra R^-1 from the reduction cancels that factor, so the output is the plain product coefficient·twiddle mod 3329 and needs no conversion afterwards. One operand pair may be issued every cycle. The output carries a valid flag exactly two clock edges after the pair is sampled.

Top module: `mm_modmul`

## Requirements
- R1: While reset is asserted and after it is released, with no operand issued, `res_valid` is 0.
- R2: An operand pair sampled with `in_valid` = 1 at clock edge n produces `res_valid` = 1 after edge n+2 only. `res_valid` is 0 in every cycle that has no matching issue two edges earlier.
- R3: For any 12-bit `op_a` and `op_b` (0 to 4095), `res` equals op_a·op_b·2^-16 mod 3329. Here 2^-16 is the inverse of 65536 modulo 3329.
- R4: When `op_b` = (w·65536) mod 3329 for a twiddle w, `res` equals op_a·w mod 3329.
- R5: Whenever `res_valid` is 1, `res` is below 3329.
- R6: When no operand is issued, `res` keeps its last value, whatever `op_a` and `op_b` carry at the time.
- R7: Pairs issued on consecutive cycles return one result per cycle, in issue order, each matching its own operands.
- R8: Boundary operands give correct results. These are 0, 1, 3328 and 4095 on either input, including the case where the intermediate quotient reaches 3329 or more and the final subtraction is needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Operand pair present this cycle |
| op_a | input | 12 | Coefficient operand |
| op_b | input | 12 | Second operand, normally a twiddle pre-scaled by 2^16 mod 3329 |
| res_valid | output | 1 | Result present this cycle |
| res | output | 12 | Product times 2^-16 modulo 3329, in [0, 3329) |

## Verification
Two functions can fall in the same cycle. Under back-to-back issue, the first register level captures a new product while the second level delivers the reduced result of the pair before it. A further overlap occurs when that delivered result also needs the final conditional subtraction. The bench provokes this by streaming twiddle sets and random and boundary operands on consecutive cycles. It judges each output, in the cycle two edges after its issue, against a value computed independently from its own operands. Idle gaps with changing operands confirm that the held result and the valid flag are left untouched.

// File: rtl/mm_pkg.sv
package mm_pkg;
  localparam int unsigned MM_W     = 12;            // operand width
  localparam int unsigned MM_HALF  = MM_W / 2;      // sub-multiplier width
  localparam int unsigned MM_PW    = 2 * MM_W;      // product width
  localparam int unsigned MM_K     = 16;            // log2 of Montgomery radix
  localparam int unsigned MM_Q     = 3329;          // 2^12 - 2^9 - 2^8 + 1
  localparam int unsigned MM_SUMW  = MM_PW + 6;     // width of T + m*q
  localparam int unsigned MM_TW    = MM_SUMW - MM_K; // quotient width

  typedef logic [MM_W-1:0]  coef_t;
  typedef logic [MM_PW-1:0] prod_t;
  typedef logic [MM_K-1:0]  mont_t;
endpackage

// File: rtl/mm_mul6.sv
module mm_mul6 #(
  parameter int unsigned N = 6
) (
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [2*N-1:0] p
);
  logic [2*N-1:0] acc [0:N];

  assign acc[0] = '0;

  // one AND row per multiplier bit, summed down a ripple chain
  for (genvar i = 0; i < N; i++) begin : g_row
    logic [2*N-1:0] row;
    assign row        = b[i] ? ({{N{1'b0}}, a} << i) : '0;
    assign acc[i + 1] = acc[i] + row;
  end

  assign p = acc[N];
endmodule

// File: rtl/mm_mul12.sv
module mm_mul12
  import mm_pkg::*;
(
  input  coef_t a,
  input  coef_t b,
  output prod_t p
);
  localparam int unsigned H = MM_HALF;

  logic [2*H-1:0] part [0:3];

  for (genvar i = 0; i < 2; i++) begin : g_ah
    for (genvar j = 0; j < 2; j++) begin : g_bh
      mm_mul6 #(.N(H)) u_sub (
        .a (a[i*H +: H]),
        .b (b[j*H +: H]),
        .p (part[2*i + j])
      );
    end
  end

  // adder tree: partial k = 2*i+j sits at bit offset (i+j)*H
  prod_t mid, lohi;
  always_comb begin
    mid  = prod_t'(part[1]) + prod_t'(part[2]);
    lohi = (prod_t'(part[3]) << (2*H)) + prod_t'(part[0]);
    p    = lohi + (mid << H);
  end
endmodule

// File: rtl/mm_redc.sv
module mm_redc
  import mm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_v,
  input  prod_t t_in,
  output logic  out_v,
  output coef_t res
);
  // ---------- level 1: m = -T * q^-1 mod 2^K ----------
  mont_t tlo, mu, m_n;
  always_comb begin
    tlo = t_in[MM_K-1:0];
    // q^-1 mod 2^16 = -(2^12 - 2^9 - 2^8 - 1)
    mu  = (tlo << 9) + (tlo << 8) + tlo - (tlo << 12);
    m_n = ~mu + mont_t'(1);
  end

  logic  v1_q, v1_n;
  prod_t t1_q;
  mont_t m1_q;

  always_comb v1_n = in_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v1_q <= 1'b0;
    else        v1_q <= v1_n;
  end

  always_ff @(posedge clk) begin
    if (in_v) begin
      t1_q <= t_in;
      m1_q <= m_n;
    end
  end

  // ---------- level 2: (T + m*q) >> K, then conditional subtract ----------
  logic [MM_SUMW-1:0] mw, mq, sum;
  logic [MM_TW-1:0]   quo;
  coef_t              res_n;
  always_comb begin
    mw    = MM_SUMW'(m1_q);
    mq    = (mw << 12) - (mw << 9) - (mw << 8) + mw;
    sum   = MM_SUMW'(t1_q) + mq;
    quo   = sum[MM_SUMW-1:MM_K];
    res_n = (quo >= MM_TW'(MM_Q)) ? MM_W'(quo - MM_TW'(MM_Q)) : MM_W'(quo);
  end

  logic  v2_q;
  coef_t r2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v2_q <= 1'b0;
    else        v2_q <= v1_q;
  end

  always_ff @(posedge clk) begin
    if (v1_q) r2_q <= res_n;
  end

  assign out_v = v2_q;
  assign res   = r2_q;

  // ---------- checks ----------
  always_comb begin
    if (v1_q) begin
      assert_exact_division_R3: assert (sum[MM_K-1:0] == '0)
        else $error("low radix bits of T+m*q not zero");
      assert_quotient_below_2q_R8: assert (quo < MM_TW'(2 * MM_Q))
        else $error("quotient out of range");
    end
  end

  assert_issue_to_level1_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_v |=> v1_q);
  assert_level1_to_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
    v1_q |=> out_v);
  assert_no_spurious_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !v1_q |=> !out_v);
  assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !v1_q |=> $stable(res));
endmodule

// File: rtl/mm_modmul.sv
module mm_modmul
  import mm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [11:0] op_a,
  input  logic [11:0] op_b,
  output logic        res_valid,
  output logic [11:0] res
);
  prod_t prod;

  mm_mul12 u_mul (
    .a (op_a),
    .b (op_b),
    .p (prod)
  );

  mm_redc u_redc (
    .clk   (clk),
    .rst_n (rst_n),
    .in_v  (in_valid),
    .t_in  (prod),
    .out_v (res_valid),
    .res   (res)
  );

  always_comb begin
    if (in_valid) begin
      assert_product_exact_R3: assert (32'(prod) == 32'(op_a) * 32'(op_b))
        else $error("integer product mismatch");
    end
  end

  assert_result_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res < 12'(MM_Q)));
endmodule

// File: tb/tb_mm_modmul.sv
module tb_mm_modmul;
  localparam int Q = 3329;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [11:0] op_a, op_b;
  logic        res_valid;
  logic [11:0] res;

  int n_chk = 0;
  int n_bad = 0;
  int rinv  = 0;

  always #2 clk = ~clk;

  mm_modmul dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .op_a(op_a), .op_b(op_b), .res_valid(res_valid), .res(res)
  );

  function automatic int exp_mont(int a, int b);
    longint t;
    t = (longint'(a) * b) % Q;
    return int'((t * rinv) % Q);
  endfunction

  function automatic int scale_tw(int w);
    return int'((longint'(w) * 65536) % Q);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // stream N pairs back to back; each result checked two edges after issue
  task automatic stream(input int av[], input int bv[], input string req);
    int n = av.size();
    for (int i = 0; i < n + 2; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        int e = exp_mont(av[i-2], bv[i-2]);
        chk(res_valid === 1'b1, {req, " valid"}, int'(res_valid), 1);
        chk(int'(res) == e, req, int'(res), e);
        chk(res < 12'(Q), "R5", int'(res), Q - 1);
      end
      if (i < n) begin
        in_valid = 1'b1; op_a = 12'(av[i]); op_b = 12'(bv[i]);
      end else begin
        in_valid = 1'b0;
      end
    end
  endtask

  task automatic t_reset;
    in_valid = 1'b0; op_a = '0; op_b = '0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(res_valid === 1'b0, "R1 in reset", int'(res_valid), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(res_valid === 1'b0, "R1 after reset", int'(res_valid), 0);
  endtask

  task automatic t_latency;
    @(negedge clk);
    in_valid = 1'b1; op_a = 12'd1234; op_b = 12'(scale_tw(17));
    @(negedge clk);
    in_valid = 1'b0;
    chk(res_valid === 1'b0, "R2 one edge", int'(res_valid), 0);
    @(negedge clk);
    chk(res_valid === 1'b1, "R2 two edges", int'(res_valid), 1);
    chk(int'(res) == (1234 * 17) % Q, "R4 single", int'(res), (1234 * 17) % Q);
    @(negedge clk);
    chk(res_valid === 1'b0, "R2 drop", int'(res_valid), 0);
  endtask

  task automatic t_twiddles;
    int av[16], bv[16], w, e;
    w = 1;
    for (int k = 0; k < 16; k++) begin
      av[k] = int'($urandom % Q);
      bv[k] = scale_tw(w);
      w = (w * 17) % Q;
    end
    stream(av, bv, "R4 twiddle stream");
    // independent form of R4: a*w mod q
    w = 1;
    for (int k = 0; k < 16; k++) begin
      e = (av[k] * w) % Q;
      chk(exp_mont(av[k], bv[k]) == e, "R4 model", exp_mont(av[k], bv[k]), e);
      w = (w * 17) % Q;
    end
  endtask

  task automatic t_random_full;
    int av[40], bv[40];
    for (int k = 0; k < 40; k++) begin
      av[k] = int'($urandom % 4096);
      bv[k] = int'($urandom % 4096);
    end
    stream(av, bv, "R3 R7 random");
  endtask

  task automatic t_bounds;
    int vals[6] = '{0, 1, 2, Q - 1, Q, 4095};
    int av[36], bv[36];
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++) begin
        av[i*6 + j] = vals[i];
        bv[i*6 + j] = vals[j];
      end
    stream(av, bv, "R8 bounds");
  endtask

  task automatic t_idle_hold;
    int held;
    @(negedge clk);
    in_valid = 1'b1; op_a = 12'd4095; op_b = 12'd4095;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    held = int'(res);
    chk(held == exp_mont(4095, 4095), "R3 held value", held, exp_mont(4095, 4095));
    for (int k = 0; k < 6; k++) begin
      op_a = 12'(k * 611 + 7); op_b = 12'(4095 - k * 333);
      @(negedge clk);
      chk(int'(res) == held, "R6 hold", int'(res), held);
      chk(res_valid === 1'b0, "R6 no valid", int'(res_valid), 0);
    end
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int x = 1; x < Q; x++)
      if ((longint'(x) * 65536) % Q == 1) rinv = x;
    t_reset();
    t_latency();
    t_twiddles();
    t_random_full();
    t_bounds();
    t_idle_hold();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule